// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This unit turns a 64-bit integer operand into an IEEE 754 value held in a 64-bit floating-point register format. A two-bit type field says how to read the operand: as a signed or unsigned integer, either 32 or 64 bits wide. A precision bit picks the result format. The result is either a binary64 value, or a binary32 value that is then written out again exactly in binary64 layout. Alongside the result the unit gives the updates for the status flags (inexact, fraction-rounded, fraction-inexact and the result class). When the record bit is set, it also gives a four-bit condition field that describes the sign of the result.

Work starts with a one-cycle `start_i` strobe. A small two-state controller runs the conversion. In `ST_IDLE` the unit waits. The transition *accept* (`ST_IDLE` to `ST_CONV`, taken when `start_i` is high) latches the operand and all control inputs. In `ST_CONV` the latched operand goes through sign and magnitude extraction, leading-zero normalisation and two rounders, one per precision. The transition *deliver* (`ST_CONV` to `ST_IDLE`, always taken) registers every output and pulses `valid_o` for one cycle. The outputs then hold their values until the next delivery. A 32-bit integer converted to a binary64 result always fits exactly. For that case the unit reports that no status flag is to be written.

Top module: `i2f_conv`

## Requirements
- R1: `itype_i` selects the source. 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 64-bit and 3 is unsigned 64-bit. The 32-bit types read only `operand_i[31:0]`, and bits 63..32 have no effect on them.
- R2: With `single_i`=0 the result is binary64: sign in bit 63, an 11-bit exponent biased by 1023 in bits 62..52, and a 52-bit fraction in bits 51..0 (for example, 1.0 is 0x3FF0000000000000).
- R3: With `single_i`=1 the value is rounded to a 24-bit significand and then written exactly in binary64 layout, so result bits 28..0 are always zero.
- R4: For types 0 and 1 with `single_i`=0, `flag_wr_o` is 0 and `xx_set_o`, `fx_set_o`, `fi_o`, `fr_o` and `class_o` are all 0.
- R5: On every other path the value is rounded using `rmode_i`: 00 is to nearest with ties to even, 01 is toward zero, 10 is toward +infinity and 11 is toward -infinity.
- R6: On the rounding paths `flag_wr_o` is 1. `xx_set_o`, `fx_set_o` and `fi_o` each equal the inexact indication, and `fr_o` is 1 exactly when the magnitude was rounded up.
- R7: On the rounding paths `class_o` is computed from the rounded result: 5'b00010 for +zero, 5'b00100 for a positive normal value and 5'b01000 for a negative normal value.
- R8: An integer zero gives +0.0, that is a result of all zero bits.
- R9: `cond_wr_o` equals the latched record bit. `cond_o` is one-hot: bit 3 means negative, bit 2 positive, bit 1 zero, and bit 0 (unordered) is always 0.
- R10: `start_i` is accepted only in `ST_IDLE`. `valid_o` is high for exactly one cycle, which begins at the second rising edge after the accepting edge. Changes to the inputs after the accepting edge, and a `start_i` held into `ST_CONV`, have no effect. After reset all outputs are 0.
- R11: When rounding carries out of the significand, the exponent goes up by one and the fraction becomes zero (for example, unsigned 64-bit 0xFFFFFFFFFFFFFFFF with nearest rounding gives 2^64 = 0x43F0000000000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| operand_i | input | 64 | Integer operand |
| itype_i | input | 2 | Source type select |
| single_i | input | 1 | 1: round to binary32 and widen |
| record_i | input | 1 | Request the condition field |
| rmode_i | input | 2 | Rounding mode |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | 64 | Converted value in binary64 layout |
| flag_wr_o | output | 1 | Status flags are to be written |
| xx_set_o | output | 1 | Set the sticky inexact flag |
| fx_set_o | output | 1 | Set the summary exception flag |
| fr_o | output | 1 | Fraction rounded (magnitude incremented) |
| fi_o | output | 1 | Fraction inexact |
| class_o | output | 5 | Result class code |
| cond_wr_o | output | 1 | Condition field is to be written |
| cond_o | output | 4 | Condition field {neg, pos, zero, unordered} |

## Verification
The bench targets 2^53+1 in binary64 under all four rounding modes. This is an exact tie, so a wrong tie-break or a swapped directional mode gives a result one unit too high or too low. It also converts 0xFFFFFFFFFFFFFFFF, where a rounder that drops its carry produces 1.0 times 2^63 instead of 2^64. The most negative signed 32-bit and 64-bit values are checked, because a magnitude taken with the wrong width comes out with the wrong sign or exponent. Further cases cover garbage in the upper operand half for 32-bit types, the exact path (where a design that rounded anyway would raise flags), and a start strobe held into the busy state, which would give a second valid pulse.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

    localparam int XLEN  = 64;
    localparam int DFRAC = 52;
    localparam int SFRAC = 23;
    localparam int DEXPW = 11;
    localparam int DBIAS = 1023;
    localparam int CLSW  = 5;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } state_e;

    localparam logic [CLSW-1:0] CLS_PZERO = 5'b00010;
    localparam logic [CLSW-1:0] CLS_PNORM = 5'b00100;
    localparam logic [CLSW-1:0] CLS_NNORM = 5'b01000;

endpackage

// File: rtl/i2f_extract.sv
module i2f_extract #(
    parameter int XW = 64,
    parameter int HW = XW / 2
) (
    input  logic [XW-1:0] operand_i,
    input  logic [1:0]    itype_i,
    output logic          sign_o,
    output logic [XW-1:0] mag_o,
    output logic          narrow_o
);
    logic [XW-1:0] src;
    logic          is_signed;

    always_comb begin
        narrow_o  = ~itype_i[1];
        is_signed = ~itype_i[0];
        if (narrow_o) begin
            if (is_signed)
                src = {{(XW-HW){operand_i[HW-1]}}, operand_i[HW-1:0]};
            else
                src = {{(XW-HW){1'b0}}, operand_i[HW-1:0]};
        end else begin
            src = operand_i;
        end
        sign_o = is_signed & src[XW-1];
        mag_o  = sign_o ? (~src + 1'b1) : src;
    end
endmodule

// File: rtl/i2f_norm.sv
module i2f_norm #(
    parameter int W  = 64,
    parameter int LW = $clog2(W)
) (
    input  logic [W-1:0]  mag_i,
    output logic [W-1:0]  norm_o,
    output logic [LW-1:0] lz_o,
    output logic          zero_o
);
    logic found;

    always_comb begin
        lz_o  = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && mag_i[i]) begin
                lz_o  = LW'(W - 1 - i);
                found = 1'b1;
            end
        end
        zero_o = ~found;
        norm_o = mag_i << lz_o;
    end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
    import i2f_pkg::*;
#(
    parameter int W  = 64,
    parameter int MW = 53
) (
    input  logic [W-1:0]  norm_i,
    input  logic          sign_i,
    input  rmode_e        rmode_i,
    output logic [MW-2:0] frac_o,
    output logic          carry_o,
    output logic          inexact_o,
    output logic          incr_o
);
    localparam int          GPOS  = W - 1 - MW;
    localparam logic [W-1:0] SMASK = {W{1'b1}} >> (MW + 1);

    logic [MW-1:0] kept;
    logic          guard;
    logic          sticky;
    logic [MW:0]   sum;

    always_comb begin
        kept      = norm_i[W-1 -: MW];
        guard     = norm_i[GPOS];
        sticky    = |(norm_i & SMASK);
        inexact_o = guard | sticky;
        unique case (rmode_i)
            RM_NEAR: incr_o = guard & (sticky | kept[0]);
            RM_ZERO: incr_o = 1'b0;
            RM_UP:   incr_o = ~sign_i & inexact_o;
            RM_DOWN: incr_o = sign_i & inexact_o;
            default: incr_o = 1'b0;
        endcase
        sum     = {1'b0, kept} + {{MW{1'b0}}, incr_o};
        carry_o = sum[MW];
        frac_o  = sum[MW-2:0];
    end
endmodule

// File: rtl/i2f_conv.sv
module i2f_conv
    import i2f_pkg::*;
#(
    parameter int XW   = XLEN,
    parameter int DFW  = DFRAC,
    parameter int SFW  = SFRAC,
    parameter int EW   = DEXPW,
    parameter int BIAS = DBIAS,
    localparam int DMW = DFW + 1,
    localparam int SMW = SFW + 1,
    localparam int LW  = $clog2(XW),
    localparam int PADW = DFW - SFW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [XW-1:0] operand_i,
    input  logic [1:0]    itype_i,
    input  logic          single_i,
    input  logic          record_i,
    input  logic [1:0]    rmode_i,
    output logic          valid_o,
    output logic [XW-1:0] result_o,
    output logic          flag_wr_o,
    output logic          xx_set_o,
    output logic          fx_set_o,
    output logic          fr_o,
    output logic          fi_o,
    output logic [CLSW-1:0] class_o,
    output logic          cond_wr_o,
    output logic [3:0]    cond_o
);
    state_e        state_q, state_n;
    logic [XW-1:0] op_q;
    logic [1:0]    itype_q;
    logic          single_q, record_q;
    rmode_e        rmode_q;

    // Datapath wires
    logic          sign_w, narrow_w, zero_w;
    logic [XW-1:0] mag_w, norm_w;
    logic [LW-1:0] lz_w;
    logic [DFW-1:0] d_frac;
    logic [SFW-1:0] s_frac;
    logic          d_carry, s_carry, d_inx, s_inx, d_inc, s_inc;

    logic          carry_sel, inx_sel, inc_sel, quiet_w;
    logic [EW-1:0] bexp_w;
    logic [DFW-1:0] frac_w;
    logic [XW-1:0] res_w;
    logic [CLSW-1:0] cls_w;
    logic [3:0]    cond_w;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_n = start_i ? ST_CONV : ST_IDLE;
            ST_CONV: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Operand capture on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            itype_q  <= '0;
            single_q <= 1'b0;
            record_q <= 1'b0;
            rmode_q  <= RM_NEAR;
        end else if (state_q == ST_IDLE && start_i) begin
            op_q     <= operand_i;
            itype_q  <= itype_i;
            single_q <= single_i;
            record_q <= record_i;
            rmode_q  <= rmode_e'(rmode_i);
        end
    end

    i2f_extract #(.XW(XW)) u_extract (
        .operand_i (op_q),
        .itype_i   (itype_q),
        .sign_o    (sign_w),
        .mag_o     (mag_w),
        .narrow_o  (narrow_w)
    );

    i2f_norm #(.W(XW)) u_norm (
        .mag_i  (mag_w),
        .norm_o (norm_w),
        .lz_o   (lz_w),
        .zero_o (zero_w)
    );

    i2f_round #(.W(XW), .MW(DMW)) u_round_dbl (
        .norm_i    (norm_w),
        .sign_i    (sign_w),
        .rmode_i   (rmode_q),
        .frac_o    (d_frac),
        .carry_o   (d_carry),
        .inexact_o (d_inx),
        .incr_o    (d_inc)
    );

    i2f_round #(.W(XW), .MW(SMW)) u_round_sgl (
        .norm_i    (norm_w),
        .sign_i    (sign_w),
        .rmode_i   (rmode_q),
        .frac_o    (s_frac),
        .carry_o   (s_carry),
        .inexact_o (s_inx),
        .incr_o    (s_inc)
    );

    // Pack into binary64 layout
    always_comb begin
        quiet_w   = narrow_w & ~single_q;
        carry_sel = single_q ? s_carry : d_carry;
        inx_sel   = single_q ? s_inx   : d_inx;
        inc_sel   = single_q ? s_inc   : d_inc;
        frac_w    = single_q ? {s_frac, {PADW{1'b0}}} : d_frac;
        bexp_w    = EW'(BIAS + (XW - 1) - int'(lz_w) + int'(carry_sel));
        res_w     = zero_w ? '0 : {sign_w, bexp_w, frac_w};
        if (zero_w)      cls_w = CLS_PZERO;
        else if (sign_w) cls_w = CLS_NNORM;
        else             cls_w = CLS_PNORM;
        cond_w = {~zero_w & sign_w, ~zero_w & ~sign_w, zero_w, 1'b0};
    end

    // Output registers, written on deliver
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            result_o  <= '0;
            flag_wr_o <= 1'b0;
            xx_set_o  <= 1'b0;
            fx_set_o  <= 1'b0;
            fr_o      <= 1'b0;
            fi_o      <= 1'b0;
            class_o   <= '0;
            cond_wr_o <= 1'b0;
            cond_o    <= '0;
        end else begin
            valid_o <= 1'b0;
            if (state_q == ST_CONV) begin
                valid_o   <= 1'b1;
                result_o  <= res_w;
                flag_wr_o <= ~quiet_w;
                xx_set_o  <= ~quiet_w & inx_sel;
                fx_set_o  <= ~quiet_w & inx_sel;
                fi_o      <= ~quiet_w & inx_sel;
                fr_o      <= ~quiet_w & inc_sel;
                class_o   <= quiet_w ? '0 : cls_w;
                cond_wr_o <= record_q;
                cond_o    <= record_q ? cond_w : 4'b0000;
            end
        end
    end

    // Assertions
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_start_to_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q == ST_IDLE) |=> ##1 valid_o);

    assert_round_up_inexact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fr_o) |-> fi_o);

    assert_class_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && flag_wr_o) |-> ($countones(class_o) == 1));

    assert_cond_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cond_wr_o |-> ($countones(cond_o) == 1 && !cond_o[0]));

    assert_exact_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !flag_wr_o) |-> (result_o[19:0] == 20'h0));

    assert_sign_matches_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cond_wr_o) |-> (cond_o[3] == result_o[XW-1]));

endmodule

// File: tb/test_i2f_conv.sv
module test_i2f_conv;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] operand_i = '0;
    logic [1:0]  itype_i = '0;
    logic        single_i = 1'b0;
    logic        record_i = 1'b0;
    logic [1:0]  rmode_i = '0;
    logic        valid_o, flag_wr_o, xx_set_o, fx_set_o, fr_o, fi_o, cond_wr_o;
    logic [63:0] result_o;
    logic [4:0]  class_o;
    logic [3:0]  cond_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2f_conv i_i2f_conv (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
        .itype_i(itype_i), .single_i(single_i), .record_i(record_i),
        .rmode_i(rmode_i), .valid_o(valid_o), .result_o(result_o),
        .flag_wr_o(flag_wr_o), .xx_set_o(xx_set_o), .fx_set_o(fx_set_o),
        .fr_o(fr_o), .fi_o(fi_o), .class_o(class_o),
        .cond_wr_o(cond_wr_o), .cond_o(cond_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Independent reference: divide-and-remainder rounding
    function automatic logic [63:0] ref_conv(input logic [63:0] op, input logic [1:0] it,
                                             input logic sp, input logic [1:0] rm,
                                             output logic inx, output logic up);
        logic        sgn;
        logic [63:0] mag, q, rem, half;
        int          k, kk, sh, p;
        logic [10:0] e;
        logic [51:0] fr;
        inx = 1'b0; up = 1'b0;
        case (it)
            2'd0: begin sgn = op[31]; mag = sgn ? (64'h1_0000_0000 - {32'h0, op[31:0]}) : {32'h0, op[31:0]}; end
            2'd1: begin sgn = 1'b0; mag = {32'h0, op[31:0]}; end
            2'd2: begin sgn = op[63]; mag = sgn ? (64'h0 - op) : op; end
            default: begin sgn = 1'b0; mag = op; end
        endcase
        if (mag == 64'h0) return 64'h0;
        k = 0;
        for (int i = 0; i < 64; i++) if (mag[i]) k = i;
        p = sp ? 24 : 53;
        sh = 0;
        q = mag;
        if (k >= p) begin
            sh   = k - p + 1;
            q    = mag >> sh;
            rem  = mag - (q << sh);
            half = 64'd1 << (sh - 1);
            inx  = (rem != 64'h0);
            case (rm)
                2'd0: up = (rem > half) || ((rem == half) && q[0]);
                2'd1: up = 1'b0;
                2'd2: up = !sgn && inx;
                default: up = sgn && inx;
            endcase
            q = q + {63'h0, up};
        end
        kk = 0;
        for (int i = 0; i < 64; i++) if (q[i]) kk = i;
        e = 11'(kk + sh + 1023);
        if (kk <= 52) fr = 52'(q << (52 - kk));
        else          fr = 52'(q >> (kk - 52));
        return {sgn, e, fr};
    endfunction

    task automatic launch(input logic [63:0] op, input logic [1:0] it, input logic sp,
                          input logic rec, input logic [1:0] rm);
        @(negedge clk);
        operand_i = op; itype_i = it; single_i = sp; record_i = rec; rmode_i = rm;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        operand_i = ~op;
        @(negedge clk);
    endtask

    task automatic run_case(input string tag, input logic [63:0] op, input logic [1:0] it,
                            input logic sp, input logic rec, input logic [1:0] rm);
        logic [63:0] er;
        logic inx, up, fw;
        logic [4:0] cls;
        logic [3:0] cnd;
        er = ref_conv(op, it, sp, rm, inx, up);
        fw = it[1] | sp;
        if (er == 64'h0)  begin cls = 5'b00010; cnd = 4'b0010; end
        else if (er[63])  begin cls = 5'b01000; cnd = 4'b1000; end
        else              begin cls = 5'b00100; cnd = 4'b0100; end
        launch(op, it, sp, rec, rm);
        chk("R10", "valid", {63'h0, valid_o}, 64'h1);
        chk(tag, "result", result_o, er);
        chk(fw ? "R6" : "R4", "flag_wr", {63'h0, flag_wr_o}, {63'h0, fw});
        chk(fw ? "R6" : "R4", "xx/fx/fi", {61'h0, xx_set_o, fx_set_o, fi_o},
            {61'h0, {3{fw & inx}}});
        chk(fw ? "R6" : "R4", "fr", {63'h0, fr_o}, {63'h0, fw & up});
        chk("R7", "class", {59'h0, class_o}, {59'h0, fw ? cls : 5'b0});
        chk("R9", "cond_wr", {63'h0, cond_wr_o}, {63'h0, rec});
        if (rec) chk("R9", "cond", {60'h0, cond_o}, {60'h0, cnd});
    endtask

    task automatic t_reset;
        chk("R10", "reset valid", {63'h0, valid_o}, 64'h0);
        chk("R10", "reset result", result_o, 64'h0);
        chk("R10", "reset flag_wr", {63'h0, flag_wr_o}, 64'h0);
        chk("R10", "reset cond_wr", {63'h0, cond_wr_o}, 64'h0);
    endtask

    task automatic t_zero;
        run_case("R8", 64'h0, 2'd2, 1'b0, 1'b1, 2'd3);
        chk("R8", "zero literal", result_o, 64'h0);
        chk("R7", "zero class", {59'h0, class_o}, {59'h0, 5'b00010});
        run_case("R8", 64'hFFFF_FFFF_0000_0000, 2'd0, 1'b1, 1'b1, 2'd0);
    endtask

    task automatic t_types;
        run_case("R1", 64'hDEAD_BEEF_FFFF_FFFF, 2'd0, 1'b0, 1'b1, 2'd0);
        chk("R1", "s32 -1 literal", result_o, 64'hBFF0_0000_0000_0000);
        run_case("R1", 64'h1234_5678_8000_0000, 2'd0, 1'b0, 1'b0, 2'd0);
        chk("R1", "s32 min literal", result_o, 64'hC1E0_0000_0000_0000);
        run_case("R1", 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 1'b1, 2'd0);
        chk("R1", "s64 -1 literal", result_o, 64'hBFF0_0000_0000_0000);
        run_case("R1", 64'h8000_0000_0000_0000, 2'd2, 1'b0, 1'b1, 2'd2);
        chk("R1", "s64 min literal", result_o, 64'hC3E0_0000_0000_0000);
        run_case("R2", 64'h0000_0000_0000_0001, 2'd3, 1'b0, 1'b0, 2'd0);
        chk("R2", "one literal", result_o, 64'h3FF0_0000_0000_0000);
    endtask

    task automatic t_exact32;
        run_case("R4", 64'hAAAA_AAAA_FFFF_FFFF, 2'd1, 1'b0, 1'b0, 2'd2);
        chk("R4", "u32 max literal", result_o, 64'h41EF_FFFF_FFE0_0000);
        chk("R4", "no flag write", {63'h0, flag_wr_o}, 64'h0);
        run_case("R4", 64'h0000_0000_7FFF_FFFF, 2'd0, 1'b0, 1'b1, 2'd3);
    endtask

    task automatic t_two53;
        logic [63:0] v;
        v = 64'h0020_0000_0000_0001;
        run_case("R5", v, 2'd3, 1'b0, 1'b0, 2'd0);
        chk("R5", "2^53+1 near", result_o, 64'h4340_0000_0000_0000);
        run_case("R5", v, 2'd3, 1'b0, 1'b0, 2'd1);
        run_case("R5", v, 2'd3, 1'b0, 1'b0, 2'd2);
        chk("R5", "2^53+1 up", result_o, 64'h4340_0000_0000_0001);
        chk("R6", "2^53+1 up fr", {63'h0, fr_o}, 64'h1);
        run_case("R5", v, 2'd3, 1'b0, 1'b0, 2'd3);
        run_case("R5", 64'h0 - v, 2'd2, 1'b0, 1'b1, 2'd3);
        chk("R5", "-(2^53+1) down", result_o, 64'hC340_0000_0000_0001);
        run_case("R5", 64'h0020_0000_0000_0003, 2'd3, 1'b0, 1'b0, 2'd0);
        chk("R5", "tie to even up", result_o, 64'h4340_0000_0000_0002);
    endtask

    task automatic t_carry;
        run_case("R11", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b1, 2'd0);
        chk("R11", "2^64 literal", result_o, 64'h43F0_0000_0000_0000);
        run_case("R11", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b0, 2'd1);
        chk("R11", "trunc no carry", result_o, 64'h43EF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_single;
        run_case("R3", 64'h0000_0000_FFFF_FFFF, 2'd1, 1'b1, 1'b0, 2'd0);
        chk("R3", "u32 max single", result_o, 64'h41F0_0000_0000_0000);
        run_case("R3", 64'h0000_0000_0100_0001, 2'd0, 1'b1, 1'b1, 2'd2);
        chk("R3", "low bits zero", {35'h0, result_o[28:0]}, 64'h0);
        run_case("R3", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 1'b0, 2'd1);
        run_case("R3", 64'hFFFF_FFFF_FEFF_FFFF, 2'd2, 1'b1, 1'b1, 2'd3);
    endtask

    task automatic t_timing;
        @(negedge clk);
        operand_i = 64'd5; itype_i = 2'd3; single_i = 1'b0; record_i = 1'b0;
        rmode_i = 2'd0; start_i = 1'b1;
        @(negedge clk);
        operand_i = 64'd9;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10", "valid after busy start", {63'h0, valid_o}, 64'h1);
        chk("R10", "late input ignored", result_o, 64'h4014_0000_0000_0000);
        @(negedge clk);
        chk("R10", "single pulse", {63'h0, valid_o}, 64'h0);
        chk("R10", "result held", result_o, 64'h4014_0000_0000_0000);
    endtask

    task automatic t_random;
        logic [63:0] op;
        for (int n = 0; n < 400; n++) begin
            op = {$urandom, $urandom} >> ($urandom % 64);
            run_case("R2", op, 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_zero();
        t_types();
        t_exact32();
        t_two53();
        t_carry();
        t_single();
        t_timing();
        t_random();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule